// File: doc/BRIEF.md
# Bubble-Tolerant Thermometer-to-Binary Encoder

This block turns the 255 latched decisions of an 8-bit flash quantizer into an 8-bit binary code. Each rising clock edge registers the comparator vector. The decode logic works only from that registered copy, and the result goes into an output register. A code therefore appears two rising edges after the comparators are presented. A new code is produced on every clock cycle.

A real comparator bank does not always give a clean run of ones. Metastable or mismatched comparators can leave isolated holes below the transition or stray ones above it. A priority encoder would turn such a pattern into a large jump, or even into a false full-scale or zero-scale reading. This block filters first. Each comparator is replaced by the majority of itself and its two neighbours. The filtered ones are then counted. A bubble far from the transition is removed entirely. A bubble right next to the transition moves the result by one step at most.

Top module: `therm_bin_encoder`

## Requirements
- R1: Bit k of `comp_i` (bit 0 is the lowest ladder tap) reads 1 when the input lies above tap k. For a clean pattern with ones exactly at bits 0..n-1, `code_o` equals n.
- R2: When all 255 comparator bits are 1 (overrange), `code_o` is 8'hFF.
- R3: When all comparator bits are 0 (underrange), `code_o` is 8'h00.
- R4: A clean pattern with ones at bits 0..127 (zero differential input) gives the mid-scale code 8'h80.
- R5: A clean level-n pattern with exactly one bit inverted at index j, where j <= n-3 or j >= n+2, still gives exactly n.
- R6: A clean level-n pattern with one bit inverted at index n-2, n-1, n or n+1 gives a code within 1 of n.
- R7: With two inverted bits, one at j <= n-3 and one at k >= n+2, the code is exactly n. With the inverted pair (n-2, n) or (n-1, n+1), the code is within 1 of n.
- R8: The vector present at a rising edge is reflected on `code_o` after the following rising edge. The block accepts a new vector on every cycle.
- R9: While `rst_n` is low, both pipeline registers are cleared and `code_o` reads 0, whatever `comp_i` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; comparator capture and output update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| comp_i | input | 255 | Comparator decisions, bit 0 at the bottom of the ladder |
| code_o | output | 8 | Registered binary result |

## Verification
The assertions assume that `comp_i` is settled and free of unknowns at every rising edge. They also assume that reset is released away from a clock edge. The bench changes `comp_i` only on falling edges, and it holds a defined value during reset. The exact-value assertions fire only when the held vector is a clean run of ones. Bubble patterns are judged by the bench's own tolerance model. Every bubble pattern is built from a known level n, so the expected code and its tolerance follow directly from R5 to R7.

// File: rtl/therm_enc_pkg.sv
package therm_enc_pkg;
  // default resolution of the quantizer
  localparam int unsigned DEF_BITS  = 8;
  // comparators summed per first-level partial counter
  localparam int unsigned DEF_GROUP = 16;
endpackage

// File: rtl/therm_capture.sv
module therm_capture #(
  parameter int unsigned TAPS = 255
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TAPS-1:0] raw_i,
  output logic [TAPS-1:0] held_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_o <= '0;
    else        held_o <= raw_i;
  end
endmodule

// File: rtl/bubble_vote.sv
module bubble_vote #(
  parameter int unsigned TAPS = 255
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TAPS-1:0] held_i,
  output logic [TAPS-1:0] clean_o
);
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic is_run(input logic [TAPS-1:0] v);
    logic [TAPS:0] inc;
    inc = {1'b0, v} + {{TAPS{1'b0}}, 1'b1};
    return ((inc[TAPS-1:0] & v) == '0);
  endfunction

  // below the bottom tap counts as 1, above the top tap as 0
  for (genvar k = 0; k < TAPS; k++) begin : g_vote
    logic below, above;
    if (k == 0) begin : g_bot
      assign below = 1'b1;
    end else begin : g_mid_lo
      assign below = held_i[k-1];
    end
    if (k == TAPS - 1) begin : g_top
      assign above = 1'b0;
    end else begin : g_mid_hi
      assign above = held_i[k+1];
    end
    assign clean_o[k] = maj3(below, held_i[k], above);
  end

  logic held_is_run;
  assign held_is_run = is_run(held_i);

  // R1
  vote_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_is_run |-> (clean_o == held_i));
endmodule

// File: rtl/ones_tally.sv
module ones_tally #(
  parameter int unsigned TAPS  = 255,
  parameter int unsigned BITS  = 8,
  parameter int unsigned GROUP = 16
) (
  input  logic [TAPS-1:0] vec_i,
  output logic [BITS-1:0] count_o
);
  localparam int unsigned NGRP = (TAPS + GROUP - 1) / GROUP;
  localparam int unsigned PADW = NGRP * GROUP;
  localparam int unsigned PW   = $clog2(GROUP + 1);
  localparam int unsigned SW   = BITS + 1;

  function automatic logic [PW-1:0] part_count(input logic [GROUP-1:0] g);
    logic [PW-1:0] s;
    s = '0;
    for (int i = 0; i < GROUP; i++) s = s + PW'(g[i]);
    return s;
  endfunction

  logic [PADW-1:0] padded;
  assign padded = {{(PADW - TAPS){1'b0}}, vec_i};

  logic [PW-1:0] part [NGRP];
  for (genvar g = 0; g < NGRP; g++) begin : g_part
    assign part[g] = part_count(padded[g*GROUP +: GROUP]);
  end

  logic [SW-1:0] total;
  always_comb begin
    total = '0;
    for (int g = 0; g < NGRP; g++) total = total + SW'(part[g]);
  end

  // at most TAPS ones, so the total always fits BITS bits
  assign count_o = total[BITS-1:0];
endmodule

// File: rtl/code_reg.sv
module code_reg #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BITS-1:0] d_i,
  output logic [BITS-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= d_i;
  end
endmodule

// File: rtl/therm_bin_encoder.sv
module therm_bin_encoder
  import therm_enc_pkg::*;
#(
  parameter int unsigned BITS  = DEF_BITS,
  parameter int unsigned GROUP = DEF_GROUP
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [(1<<BITS)-2:0]    comp_i,
  output logic [BITS-1:0]         code_o
);
  localparam int unsigned TAPS = (1 << BITS) - 1;

  logic [TAPS-1:0] held_vec;
  logic [TAPS-1:0] clean_vec;
  logic [BITS-1:0] tally;

  therm_capture #(.TAPS(TAPS)) u_cap (
    .clk(clk), .rst_n(rst_n), .raw_i(comp_i), .held_o(held_vec)
  );

  bubble_vote #(.TAPS(TAPS)) u_vote (
    .clk(clk), .rst_n(rst_n), .held_i(held_vec), .clean_o(clean_vec)
  );

  ones_tally #(.TAPS(TAPS), .BITS(BITS), .GROUP(GROUP)) u_tally (
    .vec_i(clean_vec), .count_o(tally)
  );

  code_reg #(.BITS(BITS)) u_out (
    .clk(clk), .rst_n(rst_n), .d_i(tally), .q_o(code_o)
  );

  // ---- observation points for the assertions ----
  function automatic logic is_run(input logic [TAPS-1:0] v);
    logic [TAPS:0] inc;
    inc = {1'b0, v} + {{TAPS{1'b0}}, 1'b1};
    return ((inc[TAPS-1:0] & v) == '0);
  endfunction

  // level as the index of the highest set bit plus one
  function automatic logic [BITS-1:0] top_level(input logic [TAPS-1:0] v);
    logic [BITS-1:0] r;
    r = '0;
    for (int k = 0; k < TAPS; k++) if (v[k]) r = BITS'(k + 1);
    return r;
  endfunction

  logic held_all_one, held_all_zero, held_clean;
  assign held_all_one  = &held_vec;
  assign held_all_zero = ~|held_vec;
  assign held_clean    = is_run(held_vec);

  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  // R2
  full_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_all_one |=> (code_o == {BITS{1'b1}}));

  // R3
  zero_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_all_zero |=> (code_o == '0));

  // R1
  clean_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_clean |=> (code_o == $past(top_level(held_vec))));

  // R8
  port_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((warm == 2'd2) && $past(is_run(comp_i), 2))
      |-> (code_o == $past(top_level(comp_i), 2)));

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (code_o == '0));
endmodule

// File: tb/tb_therm_bin_encoder.sv
`timescale 1ns/1ps
module tb_therm_bin_encoder;
  localparam int BITS = 8;
  localparam int TAPS = 255;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [TAPS-1:0] comp_i = '0;
  logic [BITS-1:0] code_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int    lvl;
    bit    exact;
    string tag;
  } exp_t;
  exp_t pend[$];

  always #2.5 clk = ~clk;

  therm_bin_encoder dut (.clk(clk), .rst_n(rst_n), .comp_i(comp_i), .code_o(code_o));

  function automatic logic [TAPS-1:0] level_vec(int n);
    logic [TAPS-1:0] v;
    for (int k = 0; k < TAPS; k++) v[k] = (k < n);
    return v;
  endfunction

  task automatic judge(exp_t e);
    int got, diff;
    bit ok;
    got  = int'(code_o);
    diff = (got > e.lvl) ? got - e.lvl : e.lvl - got;
    ok   = e.exact ? (diff == 0) : (diff <= 1);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: code=%0d expected %0d%s", e.tag, got, e.lvl,
               e.exact ? "" : " +/-1");
    end
  endtask

  // output at this falling edge belongs to the vector driven two falling edges ago
  task automatic apply(logic [TAPS-1:0] v, int lvl, bit exact, string tag);
    exp_t e;
    @(negedge clk);
    if (pend.size() == 2) judge(pend.pop_front());
    comp_i = v;
    e.lvl = lvl; e.exact = exact; e.tag = tag;
    pend.push_back(e);
  endtask

  initial begin
    logic [TAPS-1:0] v;
    // R9: reset holds the output at zero even with a full-scale vector present
    comp_i = '1;
    repeat (3) @(negedge clk);
    checks++;
    if (code_o !== '0) begin
      errors++;
      $display("FAIL R9: code=%0d expected 0 during reset", code_o);
    end
    rst_n  = 1'b1;
    comp_i = '0;

    // R1 R2 R3 R4 R8: every clean level, a new one on each cycle
    for (int n = 0; n <= TAPS; n++) begin
      string t;
      if (n == 0)        t = "R3";
      else if (n == TAPS) t = "R2";
      else if (n == 128) t = "R4";
      else               t = "R1/R8";
      apply(level_vec(n), n, 1'b1, t);
    end

    for (int n = 0; n <= TAPS; n++) begin
      // R5: a single far bubble leaves the code exact
      for (int j = 0; j < TAPS; j++) begin
        if ((j == n - 3) || (j == n + 2) || (j == 0 && n >= 3) || (j == TAPS - 1 && n <= TAPS - 3)) begin
          v = level_vec(n); v[j] = ~v[j];
          apply(v, n, 1'b1, "R5");
        end
      end
      // R6: a single bubble at the transition moves the code by at most one
      for (int j = n - 2; j <= n + 1; j++) begin
        if (j >= 0 && j < TAPS) begin
          v = level_vec(n); v[j] = ~v[j];
          apply(v, n, 1'b0, "R6");
        end
      end
      // R7: double bubbles
      if (n - 3 >= 0 && n + 2 < TAPS) begin
        v = level_vec(n); v[n-3] = 1'b0; v[n+2] = 1'b1;
        apply(v, n, 1'b1, "R7");
      end
      if (n - 2 >= 0 && n < TAPS) begin
        v = level_vec(n); v[n-2] = 1'b0; v[n] = 1'b1;
        apply(v, n, 1'b0, "R7");
      end
      if (n - 1 >= 0 && n + 1 < TAPS) begin
        v = level_vec(n); v[n-1] = 1'b0; v[n+1] = 1'b1;
        apply(v, n, 1'b0, "R7");
      end
    end

    // flush the last two results
    apply('0, 0, 1'b1, "R3");
    apply('0, 0, 1'b1, "R3");
    apply('0, 0, 1'b1, "R3");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule